// File: doc/BRIEF.md
# Four-Register Accumulating Processor Core

This block is the decode and datapath of a single-cycle 16-bit processor with separate instruction and data memories. Each clock it takes one 16-bit instruction and completes it in that cycle. It holds four 16-bit general registers and two status flags. The block makes no next-PC decision. It passes the branch condition bits, the branch offset, the flags and register 0 to a separate branch unit.

Two instruction formats act on the datapath. The first loads a 15-bit constant into register 0. The second computes `dst = src1 op src2` with a six-control-bit ALU. Either the first source or the destination, or both, may be indirect. An indirect operand goes through the single data-memory port. That port has one shared address, so when both ends are indirect the destination register supplies the one address and the encoded first-source field is ignored. Instructions whose two top bits are `11` are branch instructions. This block only decodes their fields.

Top module: `quad_reg_core`

## Requirements
- R1: A synchronous active-high reset clears all four registers and both flags. After reset, `r0_o` is 0 and both flag outputs are 0.
- R2: When instruction bit 15 is 0, register 0 is loaded with `{1'b0, instr[14:0]}` at the clock edge.
- R3: When bits 15:14 are `10`, the ALU format applies. The destination register is in bits 12:11, the first source in bits 9:8 and the second source in bits 1:0. With no indirection, the destination register receives the result.
- R4: The ALU control field is bits 7:2. From bit 7 down to bit 2 its bits are: zero x, invert x, zero y, invert y, function (1 = add, 0 = bitwise AND), invert output. x is the first operand and y is the second-source register.
- R5: When bit 10 (source indirect) is set, `dmem_addr_o` carries the first-source register value and x is `dmem_rdata_i`.
- R6: When bit 13 (destination indirect) is set in the ALU format, `dmem_we_o` is 1, `dmem_addr_o` is the destination register value, `dmem_wdata_o` is the result, and no register changes.
- R7: When bits 13 and 10 are both set, the destination register supplies the memory address used for both the read and the write. The bits 9:8 field is ignored.
- R8: Constant loads and ALU-format instructions set the zero flag to (result == 0) and the negative flag to result bit 15, registered at the clock edge.
- R9: When bits 15:14 are `11`, no register, flag or memory write changes. `br_valid_o` is 1, `br_cond_o` is bits 13:11 and `br_offset_o` is bits 10:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction for the current cycle |
| dmem_addr_o | output | 16 | Shared data-memory address |
| dmem_rdata_i | input | 16 | Data-memory read word |
| dmem_wdata_o | output | 16 | Data-memory write word (ALU result) |
| dmem_we_o | output | 1 | Data-memory write enable |
| flag_neg_o | output | 1 | Negative flag |
| flag_zero_o | output | 1 | Zero flag |
| r0_o | output | 16 | Register 0 value for the branch unit |
| br_valid_o | output | 1 | Current instruction is in the branch format |
| br_cond_o | output | 3 | Branch condition bits |
| br_offset_o | output | 11 | Signed branch offset field |

## Verification
The hardest case to reach from the ports is the double-indirect instruction. In that case the encoded first-source field must lose to the destination field. The case is visible only through the shared address and through the sum that uses the word read from that address. The bench models data memory as `rdata = addr ^ 0x5A5A`, so each read value depends on the address that produced it. It then issues an instruction whose first-source field names a register holding a different address. A wrong address selection produces a different write word. Registers have no port of their own, so the bench reads them back with indirect stores that pass y, or x, straight through to the write data.

// File: rtl/qrc_pkg.sv
package qrc_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned CONST_W = 15;
  localparam int unsigned CTRL_W  = 6;
  localparam int unsigned RSEL_W  = 2;

  typedef enum logic [1:0] {
    FMT_CONST  = 2'd0,
    FMT_COMPUTE = 2'd1,
    FMT_BRANCH = 2'd2
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic              dst_ind;
    logic              src_ind;
    logic [RSEL_W-1:0] dst;
    logic [RSEL_W-1:0] src1;
    logic [RSEL_W-1:0] src2;
    logic [CTRL_W-1:0] ctrl;
    logic [2:0]        cond;
    logic [10:0]       offset;
  } dec_t;

  localparam logic [CTRL_W-1:0] CTRL_PASS_X = 6'b001100;
endpackage

// File: rtl/qrc_decode.sv
module qrc_decode
  import qrc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  always_comb begin
    dec_o         = '0;
    dec_o.fmt     = instr_i[15] ? (instr_i[14] ? FMT_BRANCH : FMT_COMPUTE) : FMT_CONST;
    dec_o.dst_ind = instr_i[15] & ~instr_i[14] & instr_i[13];
    dec_o.src_ind = instr_i[15] & ~instr_i[14] & instr_i[10];
    dec_o.dst     = instr_i[12:11];
    // shared address: destination field overrides first source
    dec_o.src1    = (instr_i[13] && instr_i[10]) ? instr_i[12:11] : instr_i[9:8];
    dec_o.src2    = instr_i[1:0];
    dec_o.ctrl    = instr_i[7:2];
    dec_o.cond    = instr_i[13:11];
    dec_o.offset  = instr_i[10:0];
  end
endmodule

// File: rtl/qrc_alu.sv
module qrc_alu #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [5:0]   ctrl_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] xa, xb, ya, yb, fo;

  always_comb begin
    xa    = ctrl_i[5] ? '0 : x_i;
    xb    = ctrl_i[4] ? ~xa : xa;
    ya    = ctrl_i[3] ? '0 : y_i;
    yb    = ctrl_i[2] ? ~ya : ya;
    fo    = ctrl_i[1] ? (xb + yb) : (xb & yb);
    out_o = ctrl_i[0] ? ~fo : fo;
  end
endmodule

// File: rtl/qrc_regfile.sv
module qrc_regfile #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 4,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic [AW-1:0] rc_i,
  output logic [W-1:0]  ra_o,
  output logic [W-1:0]  rb_o,
  output logic [W-1:0]  rc_o,
  output logic [W-1:0]  r0_o
);
  logic [N-1:0][W-1:0] regs;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (we_i) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  assign ra_o = regs[ra_i];
  assign rb_o = regs[rb_i];
  assign rc_o = regs[rc_i];
  assign r0_o = regs[0];

  // R6: cycles without a register write leave every register unchanged
  p_regs_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(regs));
endmodule

// File: rtl/quad_reg_core.sv
module quad_reg_core
  import qrc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [DATA_W-1:0]  dmem_addr_o,
  input  logic [DATA_W-1:0]  dmem_rdata_i,
  output logic [DATA_W-1:0]  dmem_wdata_o,
  output logic               dmem_we_o,
  output logic               flag_neg_o,
  output logic               flag_zero_o,
  output logic [DATA_W-1:0]  r0_o,
  output logic               br_valid_o,
  output logic [2:0]         br_cond_o,
  output logic [10:0]        br_offset_o
);
  localparam int unsigned AW = $clog2(NREGS);

  dec_t              dec;
  logic [DATA_W-1:0] src1_val, src2_val, addr_val, alu_x, alu_out;
  logic [CTRL_W-1:0] alu_ctrl;
  logic [AW-1:0]     addr_sel, wsel;
  logic              is_const, is_comp, rf_we, flags_we;

  qrc_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  assign is_const = (dec.fmt == FMT_CONST);
  assign is_comp  = (dec.fmt == FMT_COMPUTE);
  assign addr_sel = dec.dst_ind ? dec.dst : dec.src1;

  qrc_regfile #(.W(DATA_W), .N(NREGS)) u_rf (
    .clk(clk), .rst(rst),
    .we_i(rf_we), .waddr_i(wsel), .wdata_i(alu_out),
    .ra_i(dec.src1), .rb_i(dec.src2), .rc_i(addr_sel),
    .ra_o(src1_val), .rb_o(src2_val), .rc_o(addr_val),
    .r0_o(r0_o)
  );

  always_comb begin
    if (is_const) begin
      alu_x    = {{(DATA_W-CONST_W){1'b0}}, instr_i[CONST_W-1:0]};
      alu_ctrl = CTRL_PASS_X;
    end else begin
      alu_x    = dec.src_ind ? dmem_rdata_i : src1_val;
      alu_ctrl = dec.ctrl;
    end
  end

  qrc_alu #(.W(DATA_W)) u_alu (
    .x_i(alu_x), .y_i(src2_val), .ctrl_i(alu_ctrl), .out_o(alu_out)
  );

  assign rf_we    = is_const | (is_comp & ~dec.dst_ind);
  assign wsel     = is_const ? '0 : dec.dst;
  assign flags_we = is_const | is_comp;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_neg_o  <= 1'b0;
      flag_zero_o <= 1'b0;
    end else if (flags_we) begin
      flag_neg_o  <= alu_out[DATA_W-1];
      flag_zero_o <= (alu_out == '0);
    end
  end

  assign dmem_addr_o  = addr_val;
  assign dmem_wdata_o = alu_out;
  assign dmem_we_o    = is_comp & dec.dst_ind;
  assign br_valid_o   = (dec.fmt == FMT_BRANCH);
  assign br_cond_o    = dec.cond;
  assign br_offset_o  = dec.offset;

  // R9: branch-format cycles leave the flags untouched
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (instr_i[15:14] == 2'b11) |=> $stable({flag_neg_o, flag_zero_o}));

  // R8: zero flag follows the previous result of a flag-setting instruction
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (instr_i[15:14] != 2'b11) |=> (flag_zero_o == ($past(dmem_wdata_o) == '0)));

  // R2: a constant load appears on register 0 one cycle later
  p_const_r0_r2: assert property (@(posedge clk) disable iff (rst)
    !instr_i[15] |=> (r0_o == $past({{(DATA_W-CONST_W){1'b0}}, instr_i[CONST_W-1:0]})));

  // R6: a memory store never coincides with a register write
  p_store_excl_r6: assert property (@(posedge clk) disable iff (rst)
    dmem_we_o |-> !rf_we);
endmodule

// File: tb/quad_reg_core_tb.sv
`timescale 1ns/1ps
module quad_reg_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [15:0] addr, rdata, wdata, r0;
  logic        we, fn, fz, bv;
  logic [2:0]  bc;
  logic [10:0] bo;
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;

  assign rdata = addr ^ 16'h5A5A;

  quad_reg_core u_dut (
    .clk(clk), .rst(rst), .instr_i(instr),
    .dmem_addr_o(addr), .dmem_rdata_i(rdata), .dmem_wdata_o(wdata),
    .dmem_we_o(we), .flag_neg_o(fn), .flag_zero_o(fz), .r0_o(r0),
    .br_valid_o(bv), .br_cond_o(bc), .br_offset_o(bo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {instr, we, addr, wdata, neg, zero}
  localparam int NV = 17;
  localparam logic [50:0] VEC [NV] = '{
    {16'h0005, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R2 R0=5
    {16'h8830, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R3 R1=R0
    {16'h9108, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R4 R2=R1+R0=10
    {16'h9A4D, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R4 R3=R2-R1=5
    {16'h9B4E, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R8 R3=R3-R2=-5
    {16'h994C, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R8 R3=R1-R0=0
    {16'hFFFF, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R9 branch, flags kept
    {16'hA0C3, 1'b1, 16'h0005, 16'h0000, 1'b0, 1'b1}, // R9 *R0=R3 still 0
    {16'hB130, 1'b1, 16'h000A, 16'h0005, 1'b0, 1'b0}, // R6 *R2=R1
    {16'h9D08, 1'b0, 16'h0005, 16'h0000, 1'b0, 1'b0}, // R5 R3=*R1+R0
    {16'hB509, 1'b1, 16'h000A, 16'h5A55, 1'b0, 1'b0}, // R7 *R2=*R2+R1
    {16'hA0C3, 1'b1, 16'h0005, 16'h5A64, 1'b0, 1'b0}, // R5 readback R3
    {16'hB301, 1'b1, 16'h000A, 16'h0004, 1'b0, 1'b0}, // R4 *R2=R3&R1
    {16'h7FFF, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R2 R0=7FFF
    {16'hB030, 1'b1, 16'h000A, 16'h7FFF, 1'b0, 1'b0}, // R6 R2 kept, R0 readback
    {16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R8 const zero sets z
    {16'hA0C3, 1'b1, 16'h0000, 16'h5A64, 1'b0, 1'b0}  // R2 addr=R0=0
  };

  initial begin
    #150000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 r0", r0, 0);
    chk("R1 flags", {fn, fz}, 0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr = VEC[i][50:35];
      #0.5;
      chk($sformatf("v%0d we R6", i), we, VEC[i][34]);
      if (VEC[i][34]) begin
        chk($sformatf("v%0d addr R7", i), addr, VEC[i][33:18]);
        chk($sformatf("v%0d wdata R3", i), wdata, VEC[i][17:2]);
      end
      @(posedge clk);
      #1;
      chk($sformatf("v%0d flags R8", i), {fn, fz}, VEC[i][1:0]);
    end

    // R9 branch field outputs
    @(negedge clk);
    instr = 16'hD2AB;
    #0.5;
    chk("R9 valid", bv, 1);
    chk("R9 cond", bc, 3'b010);
    chk("R9 offset", bo, 11'h2AB);
    chk("R9 no write", we, 0);

    // R1 reset mid-run clears registers and flags
    @(negedge clk);
    instr = 16'h4321;
    @(negedge clk);
    instr = 16'hFFFF;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 r0 cleared", r0, 0);
    chk("R1 flags cleared", {fn, fz}, 0);
    @(negedge clk);
    rst = 1'b0;
    instr = 16'hA0C3;
    #0.5;
    chk("R1 R3 cleared", wdata, 0);
    chk("R1 R0 addr", addr, 0);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule